// File: doc/BRIEF.md
# MMU Page Access Trap Logic

This block sits beside the address relocation path of a memory-management unit. For every access it compares the access type with the page's 3-bit protection code and decides three things. First, whether the page descriptor's "accessed" status bit must be set. Second, whether its "written" status bit must be set. Third, whether the MMU status register's trap flag is set and a trap request goes to the CPU. Address translation, abort generation and the descriptor storage itself live elsewhere; this block only produces one-cycle set strobes for them.

The trap condition depends on the protection code. Code 1 is read-only with a trap on reads. Code 4 is read/write with a trap on every access. Code 5 is read/write with a trap on writes. An aborted access never marks the page as accessed and never sets the trap flag. Trap enable is bit 9 of the MMU status register. The enable that counts is the value held when the current instruction began. An instruction that clears the enable and, in the same instruction, meets a trap condition therefore still traps.

All strobes are registered. They appear in the cycle after the access strobe. The trap flag is kept inside the block, so the status register can mirror it; software clears it by writing zero.

Top module: `pg_acc_trap`

## Requirements
- R1: After reset all set strobes and the trap request are low, the trap flag is 0 and the held trap enable is 0.
- R2: Protection code 1 meets the trap condition on read (acc_kind 0) and modify (acc_kind 2) accesses, not on write (acc_kind 1).
- R3: Protection code 4 meets the trap condition on read, write and modify accesses.
- R4: Protection code 5 meets the trap condition on write and modify accesses, not on read.
- R5: Protection codes 0, 2, 3, 6 and 7 never meet the trap condition: pdr_set_a, mmr_set_trap and trap_req stay low.
- R6: pdr_set_w pulses in the cycle after any non-aborted write or modify access, whatever the protection code.
- R7: An access with acc_abort high produces no strobe, no trap request and no change of the trap flag.
- R8: pdr_set_a and mmr_set_trap pulse in the cycle after a non-aborted access that meets the trap condition, whatever the trap enable.
- R9: trap_req pulses for exactly one cycle, in the cycle after a non-aborted access that meets the trap condition while the effective trap enable is 1.
- R10: The effective trap enable is ctl_trap_en in a cycle where instr_start is high, and otherwise the value ctl_trap_en had at the last instr_start. Changing ctl_trap_en inside an instruction does not affect its traps.
- R11: trap_flag becomes 1 in the same cycle as mmr_set_trap and stays 1 until a cycle with flag_wr_en high and flag_wr_val 0. A software write of 1 sets it. A trap event in the same cycle as a software clear wins.
- R12: acc_kind 3 is not an access: it produces no strobe and no trap request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_start | input | 1 | First cycle of a new instruction; samples the trap enable |
| ctl_trap_en | input | 1 | Current trap-enable bit (bit 9 of the MMU status register) |
| acc_vld | input | 1 | Access strobe |
| acc_kind | input | 2 | 0 read, 1 write, 2 modify, 3 none |
| acc_prot | input | 3 | Protection code of the selected page |
| acc_abort | input | 1 | Access is aborted |
| flag_wr_en | input | 1 | Software write to the trap flag |
| flag_wr_val | input | 1 | Value written to the trap flag |
| pdr_set_a | output | 1 | Set strobe for the descriptor's accessed bit (bit 7) |
| pdr_set_w | output | 1 | Set strobe for the descriptor's written bit |
| mmr_set_trap | output | 1 | Set strobe for the status register's trap flag |
| trap_req | output | 1 | Trap request pulse to the CPU |
| trap_flag | output | 1 | Current value of the trap flag |

## Verification
The assertions assume that instr_start, acc_vld and acc_kind are valid in every cycle and driven only from the clock domain. They also assume that acc_abort is evaluated in the same cycle as its access and not in a later one. The stimulus keeps to this: it changes inputs only on the falling edge, holds one access per instruction during the sweep, and ends every access strobe after one cycle. The sweep covers every access type, protection code, abort value and enable value. The enable input is inverted in the middle of each instruction, so that R10 is exercised on every pattern.

// File: rtl/pgtrap_pkg.sv
package pgtrap_pkg;

  localparam int KIND_W = 2;
  localparam int PROT_W = 3;

  typedef enum logic [KIND_W-1:0] {
    AK_READ   = 2'd0,
    AK_WRITE  = 2'd1,
    AK_MODIFY = 2'd2,
    AK_NONE   = 2'd3
  } acc_kind_e;

  typedef enum logic [PROT_W-1:0] {
    PR_NONE        = 3'd0,
    PR_RO_TRAP_RD  = 3'd1,
    PR_RO          = 3'd2,
    PR_RSVD3       = 3'd3,
    PR_RW_TRAP_ANY = 3'd4,
    PR_RW_TRAP_WR  = 3'd5,
    PR_RW          = 3'd6,
    PR_RSVD7       = 3'd7
  } prot_e;

  // a modify access counts as a read and as a write
  function automatic logic kind_reads(acc_kind_e k);
    return (k == AK_READ) || (k == AK_MODIFY);
  endfunction

  function automatic logic kind_writes(acc_kind_e k);
    return (k == AK_WRITE) || (k == AK_MODIFY);
  endfunction

  function automatic logic prot_trap_hit(prot_e p, acc_kind_e k);
    logic hit;
    case (p)
      PR_RO_TRAP_RD:  hit = kind_reads(k);
      PR_RW_TRAP_ANY: hit = kind_reads(k) || kind_writes(k);
      PR_RW_TRAP_WR:  hit = kind_writes(k);
      default:        hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pgtrap_eval.sv
module pgtrap_eval
  import pgtrap_pkg::*;
(
  input  logic      acc_vld,
  input  acc_kind_e kind,
  input  prot_e     prot,
  input  logic      acc_abort,
  output logic      cond_met,
  output logic      trap_hit,
  output logic      write_hit
);

  logic live;

  // live access: valid, of a real kind, and not aborted
  assign live      = acc_vld && (kind != AK_NONE) && !acc_abort;
  assign cond_met  = prot_trap_hit(prot, kind);
  assign trap_hit  = live && cond_met;
  assign write_hit = live && kind_writes(kind);

endmodule

// File: rtl/pgtrap_enable.sv
module pgtrap_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_start,
  input  logic ctl_trap_en,
  output logic en_eff
);

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           en_q <= 1'b0;
    else if (instr_start) en_q <= ctl_trap_en;
  end

  // the boundary cycle already belongs to the new instruction
  assign en_eff = instr_start ? ctl_trap_en : en_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_start && !$past(instr_start)) |-> $stable(en_eff)); // R10

endmodule

// File: rtl/pgtrap_flag.sv
module pgtrap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (wr_en)  flag <= wr_val;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(wr_en && !wr_val)) |-> flag); // R11

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag); // R11

endmodule

// File: rtl/pg_acc_trap.sv
module pg_acc_trap
  import pgtrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_start,
  input  logic              ctl_trap_en,
  input  logic              acc_vld,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [PROT_W-1:0] acc_prot,
  input  logic              acc_abort,
  input  logic              flag_wr_en,
  input  logic              flag_wr_val,
  output logic              pdr_set_a,
  output logic              pdr_set_w,
  output logic              mmr_set_trap,
  output logic              trap_req,
  output logic              trap_flag
);

  acc_kind_e kind_t;
  prot_e     prot_t;
  logic      cond_met;
  logic      trap_hit;
  logic      write_hit;
  logic      en_eff;
  logic      req_hit;

  assign kind_t = acc_kind_e'(acc_kind);
  assign prot_t = prot_e'(acc_prot);

  pgtrap_eval u_eval (
    .acc_vld   (acc_vld),
    .kind      (kind_t),
    .prot      (prot_t),
    .acc_abort (acc_abort),
    .cond_met  (cond_met),
    .trap_hit  (trap_hit),
    .write_hit (write_hit)
  );

  pgtrap_enable u_enable (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .ctl_trap_en (ctl_trap_en),
    .en_eff      (en_eff)
  );

  pgtrap_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (trap_hit),
    .wr_en  (flag_wr_en),
    .wr_val (flag_wr_val),
    .flag   (trap_flag)
  );

  assign req_hit = trap_hit && en_eff;

  logic a_q, w_q, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 1'b0;
      w_q   <= 1'b0;
      req_q <= 1'b0;
    end else begin
      a_q   <= trap_hit;
      w_q   <= write_hit;
      req_q <= req_hit;
    end
  end

  assign pdr_set_a    = a_q;
  assign mmr_set_trap = a_q;
  assign pdr_set_w    = w_q;
  assign trap_req     = req_q;

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_abort) |=> (!pdr_set_a && !pdr_set_w && !trap_req)); // R7

  AST_W_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pdr_set_w |-> $past(acc_vld && !acc_abort &&
                        (kind_t == AK_WRITE || kind_t == AK_MODIFY))); // R6

  AST_RO_NO_WRITE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && prot_t == PR_RO_TRAP_RD && kind_t == AK_WRITE) |=> !pdr_set_a); // R2

  AST_RD_NO_WR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && prot_t == PR_RW_TRAP_WR && kind_t == AK_READ) |=> !pdr_set_a); // R4

  AST_OTHER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && prot_t != PR_RO_TRAP_RD && prot_t != PR_RW_TRAP_ANY &&
     prot_t != PR_RW_TRAP_WR) |=> (!pdr_set_a && !trap_req)); // R5

  AST_REQ_WITH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> mmr_set_trap); // R9

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !en_eff) |=> !trap_req); // R10

  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && kind_t == AK_NONE) |=> (!pdr_set_a && !pdr_set_w)); // R12

  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mmr_set_trap |-> trap_flag); // R11

endmodule

// File: tb/tb_pg_acc_trap.sv
`timescale 1ns/1ps
module tb_pg_acc_trap;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_start, ctl_trap_en, acc_vld, acc_abort;
  logic [1:0] acc_kind;
  logic [2:0] acc_prot;
  logic       flag_wr_en, flag_wr_val;
  logic       pdr_set_a, pdr_set_w, mmr_set_trap, trap_req, trap_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pg_acc_trap dut (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .ctl_trap_en(ctl_trap_en),
    .acc_vld(acc_vld), .acc_kind(acc_kind), .acc_prot(acc_prot), .acc_abort(acc_abort),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
    .pdr_set_a(pdr_set_a), .pdr_set_w(pdr_set_w), .mmr_set_trap(mmr_set_trap),
    .trap_req(trap_req), .trap_flag(trap_flag)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // expected trap condition, restated from the protection code table
  function automatic logic exp_hit(int kind, int prot, int ab);
    logic rd, wr;
    rd = (kind == 0) || (kind == 2);
    wr = (kind == 1) || (kind == 2);
    if (ab != 0 || kind == 3) return 1'b0;
    if (prot == 1) return rd;
    if (prot == 4) return 1'b1;
    if (prot == 5) return wr;
    return 1'b0;
  endfunction

  function automatic string tag_a(int kind, int prot, int ab);
    if (ab != 0)   return "R7";
    if (kind == 3) return "R12";
    if (prot == 1) return "R2";
    if (prot == 4) return "R3";
    if (prot == 5) return "R4";
    return "R5";
  endfunction

  task automatic idle_inputs();
    instr_start = 1'b0; ctl_trap_en = 1'b0; acc_vld = 1'b0; acc_abort = 1'b0;
    acc_kind = 2'd0; acc_prot = 3'd0; flag_wr_en = 1'b0; flag_wr_val = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pdr_set_a", pdr_set_a, 1'b0);
    chk("R1", "pdr_set_w", pdr_set_w, 1'b0);
    chk("R1", "trap_req", trap_req, 1'b0);
    chk("R1", "trap_flag", trap_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // held enable is 0 after reset: a hitting access without a boundary does not trap
    acc_vld = 1'b1; acc_kind = 2'd0; acc_prot = 3'd4; ctl_trap_en = 1'b1;
    @(negedge clk);
    acc_vld = 1'b0;
    chk("R1", "held enable after reset", trap_req, 1'b0);
    chk("R8", "set_trap without enable", mmr_set_trap, 1'b1);

    // exhaustive sweep with the enable flipped mid-instruction
    for (int en = 0; en < 2; en++)
      for (int kind = 0; kind < 4; kind++)
        for (int prot = 0; prot < 8; prot++)
          for (int ab = 0; ab < 2; ab++) begin
            logic h, w;
            @(negedge clk);
            instr_start = 1'b1; ctl_trap_en = en[0];
            flag_wr_en = 1'b1; flag_wr_val = 1'b0;
            @(negedge clk);
            instr_start = 1'b0; flag_wr_en = 1'b0; ctl_trap_en = ~en[0];
            acc_vld = 1'b1; acc_kind = kind[1:0]; acc_prot = prot[2:0]; acc_abort = ab[0];
            @(negedge clk);
            acc_vld = 1'b0; acc_abort = 1'b0;
            h = exp_hit(kind, prot, ab);
            w = (ab == 0) && (kind == 1 || kind == 2);
            chk(tag_a(kind, prot, ab), "pdr_set_a", pdr_set_a, h);
            chk((ab != 0) ? "R7" : "R6", "pdr_set_w", pdr_set_w, w);
            chk("R8", "mmr_set_trap", mmr_set_trap, h);
            chk("R10", "trap_req", trap_req, h && (en != 0));
            chk("R11", "trap_flag", trap_flag, h);
          end

    // R9: pulse lasts one cycle
    @(negedge clk);
    instr_start = 1'b1; ctl_trap_en = 1'b1;
    acc_vld = 1'b1; acc_kind = 2'd1; acc_prot = 3'd5;
    @(negedge clk);
    instr_start = 1'b0; acc_vld = 1'b0;
    chk("R9", "trap_req pulse with same-cycle boundary", trap_req, 1'b1);
    @(negedge clk);
    chk("R9", "trap_req one cycle", trap_req, 1'b0);
    chk("R9", "pdr_set_a one cycle", pdr_set_a, 1'b0);

    // R11: sticky flag, software set/clear, set beats clear
    repeat (5) @(negedge clk);
    chk("R11", "flag holds while idle", trap_flag, 1'b1);
    flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    @(negedge clk);
    flag_wr_en = 1'b0;
    chk("R11", "flag cleared by write 0", trap_flag, 1'b0);
    flag_wr_en = 1'b1; flag_wr_val = 1'b1;
    @(negedge clk);
    flag_wr_en = 1'b0;
    chk("R11", "flag set by write 1", trap_flag, 1'b1);
    flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    acc_vld = 1'b1; acc_kind = 2'd2; acc_prot = 3'd1;
    @(negedge clk);
    flag_wr_en = 1'b0; acc_vld = 1'b0;
    chk("R11", "trap beats clear", trap_flag, 1'b1);
    chk("R11", "set_trap on modify to code 1", mmr_set_trap, 1'b1);

    // R12 / R7 with enable active: nothing fires
    acc_vld = 1'b1; acc_kind = 2'd3; acc_prot = 3'd4;
    @(negedge clk);
    acc_vld = 1'b0;
    chk("R12", "no request for kind 3", trap_req, 1'b0);
    acc_vld = 1'b1; acc_kind = 2'd2; acc_prot = 3'd4; acc_abort = 1'b1;
    @(negedge clk);
    acc_vld = 1'b0; acc_abort = 1'b0;
    chk("R7", "no request on abort", trap_req, 1'b0);
    chk("R7", "flag unchanged on abort", trap_flag, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule